// File: doc/BRIEF.md
# Raster Position Interrupt Timer

This block raises an interrupt when the video beam reaches a programmed raster position. Each cycle it is handed the current horizontal position in master clocks (0 to 1363 across one line), the current line number, a region select (262-line or 312-line frame) and the interlace field bit. The block itself advances one master clock per cycle. It compares the position against a programmed dot target and line target and sets an interrupt flag.

Two enable bits pick how the targets are used. The horizontal enable alone fires once per line at a dot. The vertical enable alone fires on entering a line. Both together fire at one dot of one line per frame. In every mode the flag is set only when an internal match condition goes from false to true. The flag then stays set until software reads the acknowledge port. That read returns the flag in the top bit, with the open-bus bits below it, and clears the flag.

Top module: `raster_irq_timer`

## Requirements
- R1: With only the horizontal enable set, the flag is set when `hcount` equals four times the dot target, on any line. This repeats on every line, and no other `hcount` value sets it.
- R2: With only the vertical enable set, the match condition is true for every cycle where `vcount` equals the line target. The flag is set on the first such cycle.
- R3: With both enables set, the flag is set only when `vcount*1364 + hcount` reaches `line_target*1364 + dot_target*4`. A matching dot on another line does not set it. A target that lies behind the current position is moved one frame ahead: 262 lines for `pal_mode`=0, 312 for `pal_mode`=1, plus one line when `odd_field`=1. Such a target fires at its position in the next frame.
- R4: The flag is set only on a false-to-true change of the match condition. While the condition stays true after a clearing read, the flag stays clear.
- R5: With both enables clear, the match condition is false and no new event is set. A flag that is already set is held until it is read.
- R6: A cycle with `ack_rd`=1 loads `rd_data` with bit 7 = the flag and bits 6:0 = `bus_latch`. Both values are taken from that cycle. The flag reads 0 in the next cycle. Without a read, a set flag stays set.
- R7: When a read and a new event fall in the same cycle, the flag stays 1 and `rd_data` bit 7 shows the flag value from before that cycle.
- R8: Reset clears both enables, both targets, the match history, the flag and `rd_data`.
- R9: The enables and targets are loaded only in a cycle with `cfg_we`=1, and they take effect from the next cycle. The `cfg_*` values have no effect while `cfg_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| hcount | input | 11 | Horizontal position in master clocks |
| vcount | input | 9 | Current line number |
| pal_mode | input | 1 | 1 selects the 312-line frame, 0 the 262-line frame |
| odd_field | input | 1 | Interlace field bit; adds one line to the frame |
| cfg_we | input | 1 | Load enables and targets |
| cfg_h_en | input | 1 | Horizontal enable value |
| cfg_v_en | input | 1 | Vertical enable value |
| cfg_dot_target | input | 9 | Dot target, scaled by 4 to master clocks |
| cfg_line_target | input | 9 | Line target |
| ack_rd | input | 1 | Read of the acknowledge port |
| bus_latch | input | 7 | Open-bus bits returned in bits 6:0 |
| irq_flag | output | 1 | Interrupt flag |
| rd_data | output | 8 | Registered read data |

## Verification
A position presented in cycle N shows up on `irq_flag` after the clock edge that ends cycle N. A read in cycle N shows up on `rd_data`, and its clearing on `irq_flag`, after that same edge. A configuration write takes effect for positions presented from the following cycle. The driver stamps every expected item with its due cycle, the current cycle plus one. The monitor compares only on the falling clock edge of that cycle, and any item still queued at the end counts as a failure.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_DOT  = 2'd1,
    TRIG_LINE = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_mode_e;

  function automatic trig_mode_e trig_mode(input logic h_en, input logic v_en);
    return trig_mode_e'({v_en, h_en});
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int HT_W = 9,
  parameter int VT_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic            h_en_i,
  input  logic            v_en_i,
  input  logic [HT_W-1:0] dot_i,
  input  logic [VT_W-1:0] line_i,
  output logic            h_en,
  output logic            v_en,
  output logic [HT_W-1:0] dot_tgt,
  output logic [VT_W-1:0] line_tgt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_en     <= 1'b0;
      v_en     <= 1'b0;
      dot_tgt  <= '0;
      line_tgt <= '0;
    end else if (we) begin
      h_en     <= h_en_i;
      v_en     <= v_en_i;
      dot_tgt  <= dot_i;
      line_tgt <= line_i;
    end
  end

endmodule

// File: rtl/irq_pos_compare.sv
module irq_pos_compare
  import raster_irq_pkg::*;
#(
  parameter int H_W        = 11,
  parameter int V_W        = 9,
  parameter int HT_W       = 9,
  parameter int VT_W       = 9,
  parameter int LINE_CLKS  = 1364,
  parameter int DOT_SCALE  = 4,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 312,
  parameter int STEP       = 1
) (
  input  logic            h_en,
  input  logic            v_en,
  input  logic [HT_W-1:0] dot_tgt,
  input  logic [VT_W-1:0] line_tgt,
  input  logic [H_W-1:0]  hcount,
  input  logic [V_W-1:0]  vcount,
  input  logic            pal_mode,
  input  logic            odd_field,
  output logic            valid
);

  localparam int MAX_LINES = ((PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES) + 1;
  localparam int POS_W = $clog2(((1 << VT_W) + (1 << V_W) + MAX_LINES + 2) * LINE_CLKS);
  localparam int CMP_W = (V_W > VT_W) ? V_W : VT_W;

  trig_mode_e       mode;
  logic [POS_W-1:0] cur, tgt, dot_clks, frame_lines;

  always_comb begin
    mode        = trig_mode(h_en, v_en);
    dot_clks    = POS_W'(dot_tgt) * POS_W'(DOT_SCALE);
    frame_lines = POS_W'(pal_mode ? PAL_LINES : NTSC_LINES) + POS_W'(odd_field);
    cur         = '0;
    tgt         = '0;
    valid       = 1'b0;
    unique case (mode)
      TRIG_BOTH: begin
        cur = POS_W'(vcount) * POS_W'(LINE_CLKS) + POS_W'(hcount);
        tgt = POS_W'(line_tgt) * POS_W'(LINE_CLKS) + dot_clks;
        if (cur > tgt) tgt = tgt + frame_lines * POS_W'(LINE_CLKS);
        valid = (cur <= tgt) && (cur + POS_W'(STEP) > tgt);
      end
      TRIG_DOT: begin
        cur = POS_W'(hcount);
        tgt = dot_clks;
        if (cur > tgt) tgt = tgt + POS_W'(LINE_CLKS);
        valid = (cur <= tgt) && (cur + POS_W'(STEP) > tgt);
      end
      TRIG_LINE: valid = (CMP_W'(vcount) == CMP_W'(line_tgt));
      default:   valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              ack_rd,
  input  logic [DATA_W-2:0] bus_latch,
  output logic              irq_flag,
  output logic [DATA_W-1:0] rd_data
);

  logic valid_q;
  logic set_evt;

  assign set_evt = valid & ~valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      irq_flag <= 1'b0;
      rd_data  <= '0;
    end else begin
      valid_q <= valid;
      if (set_evt)     irq_flag <= 1'b1;
      else if (ack_rd) irq_flag <= 1'b0;
      if (ack_rd)      rd_data  <= {irq_flag, bus_latch};
    end
  end

endmodule

// File: rtl/raster_irq_timer.sv
module raster_irq_timer #(
  parameter int H_W        = 11,
  parameter int V_W        = 9,
  parameter int HT_W       = 9,
  parameter int VT_W       = 9,
  parameter int DATA_W     = 8,
  parameter int LINE_CLKS  = 1364,
  parameter int DOT_SCALE  = 4,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 312
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [H_W-1:0]    hcount,
  input  logic [V_W-1:0]    vcount,
  input  logic              pal_mode,
  input  logic              odd_field,
  input  logic              cfg_we,
  input  logic              cfg_h_en,
  input  logic              cfg_v_en,
  input  logic [HT_W-1:0]   cfg_dot_target,
  input  logic [VT_W-1:0]   cfg_line_target,
  input  logic              ack_rd,
  input  logic [DATA_W-2:0] bus_latch,
  output logic              irq_flag,
  output logic [DATA_W-1:0] rd_data
);

  logic            en_h, en_v, cmp_valid;
  logic [HT_W-1:0] dot_tgt;
  logic [VT_W-1:0] line_tgt;

  irq_cfg_regs #(.HT_W(HT_W), .VT_W(VT_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we),
    .h_en_i(cfg_h_en), .v_en_i(cfg_v_en),
    .dot_i(cfg_dot_target), .line_i(cfg_line_target),
    .h_en(en_h), .v_en(en_v), .dot_tgt(dot_tgt), .line_tgt(line_tgt)
  );

  irq_pos_compare #(
    .H_W(H_W), .V_W(V_W), .HT_W(HT_W), .VT_W(VT_W),
    .LINE_CLKS(LINE_CLKS), .DOT_SCALE(DOT_SCALE),
    .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES), .STEP(1)
  ) u_cmp (
    .h_en(en_h), .v_en(en_v), .dot_tgt(dot_tgt), .line_tgt(line_tgt),
    .hcount(hcount), .vcount(vcount), .pal_mode(pal_mode),
    .odd_field(odd_field), .valid(cmp_valid)
  );

  irq_flag_ctrl #(.DATA_W(DATA_W)) u_flag (
    .clk(clk), .rst(rst), .valid(cmp_valid), .ack_rd(ack_rd),
    .bus_latch(bus_latch), .irq_flag(irq_flag), .rd_data(rd_data)
  );

endmodule

// File: rtl/raster_irq_timer_chk.sv
module raster_irq_timer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ack_rd,
  input logic [DATA_W-2:0] bus_latch,
  input logic              en_h,
  input logic              en_v,
  input logic              cmp_valid,
  input logic              irq_flag,
  input logic [DATA_W-1:0] rd_data
);

  logic prev_valid;

  always_ff @(posedge clk) begin
    if (rst) prev_valid <= 1'b0;
    else     prev_valid <= cmp_valid;
  end

  p_off_no_event_r5: assert property (@(posedge clk) disable iff (rst)
    (!en_h && !en_v && !irq_flag) |=> !irq_flag);

  p_rise_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !prev_valid) |=> irq_flag);

  p_no_set_without_match_r4: assert property (@(posedge clk) disable iff (rst)
    (!cmp_valid && !irq_flag) |=> !irq_flag);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !cmp_valid) |=> !irq_flag);

  p_flag_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !ack_rd) |=> irq_flag);

  p_read_data_r6: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> (rd_data == {$past(irq_flag), $past(bus_latch)}));

  p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && cmp_valid && !prev_valid) |=> irq_flag);

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (!irq_flag && rd_data == '0));

endmodule

bind raster_irq_timer raster_irq_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ack_rd(ack_rd), .bus_latch(bus_latch),
  .en_h(en_h), .en_v(en_v), .cmp_valid(cmp_valid),
  .irq_flag(irq_flag), .rd_data(rd_data)
);

// File: tb/raster_irq_timer_tb.sv
module raster_irq_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] hcount = '0;
  logic [8:0]  vcount = '0;
  logic        pal_mode = 1'b0, odd_field = 1'b0;
  logic        cfg_we = 1'b0, cfg_h_en = 1'b0, cfg_v_en = 1'b0;
  logic [8:0]  cfg_dot_target = '0, cfg_line_target = '0;
  logic        ack_rd = 1'b0;
  logic [6:0]  bus_latch = '0;
  logic        irq_flag;
  logic [7:0]  rd_data;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    bit         is_rd;
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t q[$];

  raster_irq_timer u_dut (
    .clk(clk), .rst(rst), .hcount(hcount), .vcount(vcount),
    .pal_mode(pal_mode), .odd_field(odd_field), .cfg_we(cfg_we),
    .cfg_h_en(cfg_h_en), .cfg_v_en(cfg_v_en),
    .cfg_dot_target(cfg_dot_target), .cfg_line_target(cfg_line_target),
    .ack_rd(ack_rd), .bus_latch(bus_latch),
    .irq_flag(irq_flag), .rd_data(rd_data)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares the results due in the current cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      logic [7:0] act;
      e = q.pop_front();
      act = e.is_rd ? rd_data : {7'd0, irq_flag};
      checks++;
      if (act !== e.val) begin
        failures++;
        $display("FAIL %s %s actual=%02h expected=%02h cycle=%0d",
                 e.tag, e.is_rd ? "rd_data" : "irq_flag", act, e.val, cyc);
      end
    end
  end

  task automatic drive(input int h, input int v, input bit rd = 0, input logic [6:0] lat = 7'd0);
    @(negedge clk);
    hcount    = 11'(h);
    vcount    = 9'(v);
    ack_rd    = rd;
    bus_latch = lat;
  endtask

  task automatic expf(input bit val, input string tag);
    q.push_back('{cyc + 1, 1'b0, {7'd0, val}, tag});
  endtask

  task automatic expr(input logic [7:0] val, input string tag);
    q.push_back('{cyc + 1, 1'b1, val, tag});
  endtask

  // Parks at a position no test target matches, then writes the config
  task automatic cfg(input bit he, input bit ve, input int dot, input int line);
    drive(1000, 400);
    cfg_we = 1; cfg_h_en = he; cfg_v_en = ve;
    cfg_dot_target = 9'(dot); cfg_line_target = 9'(line);
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R8: reset state; zero targets at position 0 must not fire
    drive(0, 0);            expf(0, "R8");
    drive(0, 0);            expf(0, "R8");
    drive(5, 0, 1, 7'h55);  expr(8'h55, "R6"); expf(0, "R6");

    // R9: config inputs without cfg_we have no effect
    cfg_v_en = 1; cfg_line_target = 9'd7;
    drive(0, 7);            expf(0, "R9");
    drive(0, 7);            expf(0, "R9");
    cfg_v_en = 0; cfg_line_target = 9'd0;

    // R1: horizontal only, target 10 -> hcount 40
    cfg(1, 0, 10, 0);
    drive(38, 5);           expf(0, "R1");
    drive(39, 5);           expf(0, "R1");
    drive(40, 5);           expf(1, "R1");
    drive(41, 5);           expf(1, "R6");
    drive(42, 5, 1, 7'h2A); expr(8'hAA, "R6"); expf(0, "R6");
    drive(43, 5);           expf(0, "R1");
    drive(40, 6);           expf(1, "R1");
    drive(44, 6, 1, 7'h00); expr(8'h80, "R6"); expf(0, "R6");

    // R7: read and new event in one cycle
    drive(40, 7, 1, 7'h7F); expr(8'h7F, "R7"); expf(1, "R7");
    drive(50, 7, 1, 7'h00); expr(8'h80, "R7"); expf(0, "R7");

    // R2 / R4: vertical only, target line 100
    cfg(0, 1, 0, 100);
    drive(0, 99);           expf(0, "R2");
    drive(1363, 99);        expf(0, "R2");
    drive(0, 100);          expf(1, "R2");
    drive(1, 100, 1, 7'h01);expr(8'h81, "R6"); expf(0, "R6");
    drive(2, 100);          expf(0, "R4");
    drive(3, 100);          expf(0, "R4");
    drive(0, 101);          expf(0, "R2");
    drive(0, 100);          expf(1, "R2");
    drive(5, 101, 1, 7'h00);expf(0, "R6");

    // R3: both enables, line 3 dot 5 -> position 3*1364+20
    cfg(1, 1, 5, 3);
    drive(20, 2);           expf(0, "R3");
    drive(20, 5);           expf(0, "R3");
    drive(19, 3);           expf(0, "R3");
    drive(20, 3);           expf(1, "R3");
    drive(21, 3, 1, 7'h00); expr(8'h80, "R3"); expf(0, "R3");

    // R3: target behind the position wraps to the next frame
    pal_mode = 1; odd_field = 1;
    cfg(1, 1, 0, 0);
    drive(0, 2);            expf(0, "R3");
    drive(0, 0);            expf(1, "R3");

    // R5: both enables clear; held flag stays until read
    cfg(0, 0, 0, 0);
    drive(0, 0);            expf(1, "R5");
    drive(1, 0, 1, 7'h00);  expr(8'h80, "R5"); expf(0, "R5");
    drive(0, 0);            expf(0, "R5");
    drive(0, 0);            expf(0, "R5");
    pal_mode = 0; odd_field = 0;

    // R8: reset mid-run clears flag and config
    cfg(1, 0, 10, 0);
    drive(40, 1);           expf(1, "R1");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    drive(40, 2);           expf(0, "R8");
    drive(41, 2, 1, 7'h00); expr(8'h00, "R8");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      failures += q.size();
      $display("FAIL pending %0d expected items never compared", q.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule